// File: doc/BRIEF.md
# Power Button Sleep State Controller

This block keeps track of the system power state and drives two active-low power plane controls. The states are working (S0), the light sleep S1, suspend-to-RAM (S3), suspend-to-disk (S4) and soft-off (S5). It watches an active-low power button. That button is synchronized, debounced and timed against a slow real-time clock tick enable.

A recognized button press behaves in one of two ways:
- While the system is working, the press raises a one-cycle request toward the system management or ACPI interrupt logic. The state does not change.
- While the system is asleep, the press produces a one-cycle wake event and the state returns to S0.

Holding the button for the override time forces soft-off from any state. After that forced entry only the button can bring the system back, and the other wake input is ignored.

Software enters sleep by presenting a target-state code together with a request strobe. A power-good input may change at any time. It is synchronized and drives the bus reset output. When it stays low for enough tick periods, it also triggers a full power reset, which leaves the state in soft-off.

Top module: `pwr_btn_sleep_ctrl`

## Requirements
- R1: After reset the state code is 0 (S0), both plane controls are high, and neither pulse output is active.
- R2: A debounced button press while in S0 produces exactly one single-cycle `smi_sci_req` pulse and leaves the state at S0.
- R3: A debounced button press in any sleep state produces exactly one single-cycle `wake_evt` pulse and returns the state to S0.
- R4: A sleep request is taken only in S0. Only the target codes 1 (S1), 3 (S3), 4 (S4) and 5 (S5) are accepted. A request with any other code, or a request made outside S0, leaves the state unchanged.
- R5: `slp_s3_n` is low exactly in states 3, 4 and 5. `slp_s5_n` is low exactly in states 4 and 5.
- R6: A button level change that lasts fewer than `DB_TICKS` ticks is not recognized as a press.
- R7: A button held pressed for `HOLD_TICKS` ticks past debounce forces state 5 from any state. A release before that count causes no override.
- R8: After an override entry to S5, `ext_wake` has no effect and only the button wakes the system. Outside that lock, `ext_wake` in a sleep state produces a wake pulse and S0.
- R9: While `pwr_good` is low, `bus_rst_n` is low no later than two clocks after the input falls. `bus_rst_n` is high once `pwr_good` has been high for two clocks.
- R10: `full_rst` pulses once only when `pwr_good` stays low for `PG_TICKS` ticks. A full reset sets the state to 5 and clears the override lock. Shorter low pulses cause neither effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable at the real-time clock rate |
| btn_n | input | 1 | Power button, low when pressed, asynchronous |
| pwr_good | input | 1 | Power-good indication, asynchronous |
| ext_wake | input | 1 | Other wake source, synchronous level |
| slp_req | input | 1 | Software sleep request strobe |
| slp_target | input | 3 | Requested sleep state code |
| smi_sci_req | output | 1 | One-cycle sleep-request interrupt pulse |
| wake_evt | output | 1 | One-cycle wake event pulse |
| full_rst | output | 1 | One-cycle full power reset pulse |
| slp_s3_n | output | 1 | Active-low plane control for S3 and deeper |
| slp_s5_n | output | 1 | Active-low plane control for S4 and S5 |
| bus_rst_n | output | 1 | Active-low bus reset |
| state_o | output | 3 | Current power state code |

## Verification
The bench builds the block with `DB_TICKS` = 2, `HOLD_TICKS` = 8 and `PG_TICKS` = 3, and holds `rtc_tick` high. With these values, the button override and the power-loss filter trip within a few dozen clocks instead of seconds. The debounce window is narrow enough that a one-clock glitch and a five-clock press fall on opposite sides of the thresholds. Presses of 5 and 20 clocks straddle the hold threshold. Power-good drops of 1 and 10 clocks straddle the reset filter.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    ST_S0 = 3'd0,
    ST_S1 = 3'd1,
    ST_S3 = 3'd3,
    ST_S4 = 3'd4,
    ST_S5 = 3'd5
  } pwr_state_e;

  function automatic logic target_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd3) || (code == 3'd4) || (code == 3'd5);
  endfunction

endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/pbs_btn_timer.sv
module pbs_btn_timer #(
  parameter int DB_TICKS   = 16,
  parameter int HOLD_TICKS = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pressed_raw,
  output logic press_p,
  output logic hold_p
);

  localparam int DBW = $clog2(DB_TICKS + 1);
  localparam int HW  = $clog2(HOLD_TICKS + 1);
  localparam logic [DBW-1:0] DB_LAST   = DBW'(DB_TICKS - 1);
  localparam logic [HW-1:0]  HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic           db_q, db_d;
  logic [DBW-1:0] db_cnt_q, db_cnt_d;
  logic [HW-1:0]  hold_cnt_q, hold_cnt_d;
  logic           fired_q, fired_d;
  logic           press_d, hold_d;
  logic           press_q, hold_q;

  always_comb begin
    db_d       = db_q;
    db_cnt_d   = db_cnt_q;
    hold_cnt_d = hold_cnt_q;
    fired_d    = fired_q;
    press_d    = 1'b0;
    hold_d     = 1'b0;
    // debounce: a new level must persist for DB_TICKS ticks
    if (pressed_raw == db_q) begin
      db_cnt_d = '0;
    end else if (tick) begin
      if (db_cnt_q == DB_LAST) begin
        db_d     = pressed_raw;
        db_cnt_d = '0;
        press_d  = pressed_raw;
      end else begin
        db_cnt_d = db_cnt_q + 1'b1;
      end
    end
    // hold timer: runs while the debounced level is pressed
    if (!db_q) begin
      hold_cnt_d = '0;
      fired_d    = 1'b0;
    end else if (tick && !fired_q) begin
      if (hold_cnt_q == HOLD_LAST) begin
        hold_d  = 1'b1;
        fired_d = 1'b1;
      end else begin
        hold_cnt_d = hold_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q       <= 1'b0;
      db_cnt_q   <= '0;
      hold_cnt_q <= '0;
      fired_q    <= 1'b0;
      press_q    <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      db_q       <= db_d;
      db_cnt_q   <= db_cnt_d;
      hold_cnt_q <= hold_cnt_d;
      fired_q    <= fired_d;
      press_q    <= press_d;
      hold_q     <= hold_d;
    end
  end

  assign press_p = press_q;
  assign hold_p  = hold_q;

  AST_HOLD_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> $past(db_q)); // R7
  AST_PRESS_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    press_q |=> !press_q); // R6

endmodule

// File: rtl/pbs_pg_filter.sv
module pbs_pg_filter #(
  parameter int PG_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pg_s,
  output logic full_p
);

  localparam int CW = $clog2(PG_TICKS + 1);
  localparam logic [CW-1:0] PG_LAST = CW'(PG_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          full_q, full_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    full_d = 1'b0;
    if (pg_s) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == PG_LAST) begin
        full_d = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      full_q <= full_d;
    end
  end

  assign full_p = full_q;

  AST_FULL_RST_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !$past(pg_s)); // R10

endmodule

// File: rtl/pwr_btn_sleep_ctrl.sv
module pwr_btn_sleep_ctrl
  import pbs_pkg::*;
#(
  parameter int DB_TICKS   = 16,
  parameter int HOLD_TICKS = 131072,
  parameter int PG_TICKS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_tick,
  input  logic       btn_n,
  input  logic       pwr_good,
  input  logic       ext_wake,
  input  logic       slp_req,
  input  logic [2:0] slp_target,
  output logic       smi_sci_req,
  output logic       wake_evt,
  output logic       full_rst,
  output logic       slp_s3_n,
  output logic       slp_s5_n,
  output logic       bus_rst_n,
  output logic [2:0] state_o
);

  logic [1:0] async_in, sync_out;
  logic       btn_s, pg_s;
  logic       press_p, hold_p, full_p;

  assign async_in = {pwr_good, btn_n};

  pbs_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(async_in),
    .q_sync (sync_out)
  );

  assign btn_s = sync_out[0];
  assign pg_s  = sync_out[1];

  pbs_btn_timer #(.DB_TICKS(DB_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_btn (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (rtc_tick),
    .pressed_raw(~btn_s),
    .press_p    (press_p),
    .hold_p     (hold_p)
  );

  pbs_pg_filter #(.PG_TICKS(PG_TICKS)) u_pg (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (rtc_tick),
    .pg_s  (pg_s),
    .full_p(full_p)
  );

  pwr_state_e st_q, st_d;
  logic       lock_q, lock_d;
  logic       smi_q, smi_d;
  logic       wake_q, wake_d;

  always_comb begin
    st_d   = st_q;
    lock_d = lock_q;
    smi_d  = 1'b0;
    wake_d = 1'b0;
    if (full_p) begin
      st_d   = ST_S5;
      lock_d = 1'b0;
    end else if (hold_p) begin
      st_d   = ST_S5;
      lock_d = 1'b1;
    end else if (press_p) begin
      if (st_q == ST_S0) begin
        smi_d = 1'b1;
      end else begin
        st_d   = ST_S0;
        wake_d = 1'b1;
        lock_d = 1'b0;
      end
    end else if (ext_wake && (st_q != ST_S0) && !lock_q) begin
      st_d   = ST_S0;
      wake_d = 1'b1;
    end else if (slp_req && (st_q == ST_S0) && target_ok(slp_target)) begin
      st_d = pwr_state_e'(slp_target);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_S0;
      lock_q <= 1'b0;
      smi_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
      smi_q  <= smi_d;
      wake_q <= wake_d;
    end
  end

  assign smi_sci_req = smi_q;
  assign wake_evt    = wake_q;
  assign full_rst    = full_p;
  assign state_o     = st_q;
  assign slp_s3_n    = !((st_q == ST_S3) || (st_q == ST_S4) || (st_q == ST_S5));
  assign slp_s5_n    = !((st_q == ST_S4) || (st_q == ST_S5));
  assign bus_rst_n   = pg_s;

  AST_S5_PLANE_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s5_n |-> !slp_s3_n); // R5
  AST_WAKE_LANDS_S0: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (state_o == 3'd0)); // R3
  AST_SMI_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_sci_req |-> (state_o == 3'd0) && ($past(state_o) == 3'd0)); // R2
  AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_sci_req |=> !smi_sci_req); // R2
  AST_SLEEP_FROM_S0: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o != $past(state_o)) && (state_o != 3'd0) && (state_o != 3'd5))
      |-> ($past(state_o) == 3'd0)); // R4
  AST_LOCK_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && ext_wake && !press_p && !full_p) |=> (state_o == 3'd5)); // R8

endmodule

// File: tb/pwr_btn_sleep_ctrl_tb.sv
module pwr_btn_sleep_ctrl_tb;

  localparam time CLK_PERIOD = 10ns;

  logic clk, rst_n, rtc_tick, btn_n, pwr_good, ext_wake, slp_req;
  logic [2:0] slp_target;
  logic smi_sci_req, wake_evt, full_rst, slp_s3_n, slp_s5_n, bus_rst_n;
  logic [2:0] state_o;

  int checks, errors;
  int smi_cnt, wake_cnt, full_cnt;
  bit done;

  // {target[2:0], expected state[2:0], expected slp_s3_n, expected slp_s5_n}
  localparam logic [7:0] VEC [0:6] = '{
    8'b001_001_1_1,
    8'b011_011_0_1,
    8'b100_100_0_0,
    8'b101_101_0_0,
    8'b010_000_1_1,
    8'b000_000_1_1,
    8'b111_000_1_1
  };

  pwr_btn_sleep_ctrl #(.DB_TICKS(2), .HOLD_TICKS(8), .PG_TICKS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .btn_n(btn_n),
    .pwr_good(pwr_good), .ext_wake(ext_wake), .slp_req(slp_req),
    .slp_target(slp_target), .smi_sci_req(smi_sci_req), .wake_evt(wake_evt),
    .full_rst(full_rst), .slp_s3_n(slp_s3_n), .slp_s5_n(slp_s5_n),
    .bus_rst_n(bus_rst_n), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (smi_sci_req) smi_cnt++;
      if (wake_evt)    wake_cnt++;
      if (full_rst)    full_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n);
    @(negedge clk) btn_n = 1'b0;
    wait_n(n);
    btn_n = 1'b1;
    wait_n(14);
  endtask

  task automatic sleep_req(input logic [2:0] t);
    @(negedge clk);
    slp_req = 1'b1;
    slp_target = t;
    @(negedge clk);
    slp_req = 1'b0;
    wait_n(2);
  endtask

  task automatic pulse_ext;
    @(negedge clk) ext_wake = 1'b1;
    @(negedge clk) ext_wake = 1'b0;
    wait_n(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, s;
    rst_n = 1'b0; rtc_tick = 1'b1; btn_n = 1'b1; pwr_good = 1'b1;
    ext_wake = 1'b0; slp_req = 1'b0; slp_target = 3'd0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 slp_s3_n", slp_s3_n, 1);
    check("R1 slp_s5_n", slp_s5_n, 1);
    check("R1 pulses", smi_cnt + wake_cnt + full_cnt, 0);
    check("R9 bus_rst_n high", bus_rst_n, 1);

    // R2 short press while working
    press(5);
    check("R2 smi count", smi_cnt, 1);
    check("R2 state", state_o, 0);
    check("R2 no wake", wake_cnt, 0);

    // R6 one-clock glitch ignored
    @(negedge clk) btn_n = 1'b0;
    @(negedge clk) btn_n = 1'b1;
    wait_n(14);
    check("R6 glitch smi", smi_cnt, 1);

    // Table walk: R4 R5 R3
    for (int i = 0; i < 7; i++) begin
      sleep_req(VEC[i][7:5]);
      check("R4 state", state_o, int'(VEC[i][4:2]));
      check("R5 slp_s3_n", slp_s3_n, int'(VEC[i][1]));
      check("R5 slp_s5_n", slp_s5_n, int'(VEC[i][0]));
      if (VEC[i][4:2] != 3'd0) begin
        sleep_req(3'd1);
        check("R4 request outside S0", state_o, int'(VEC[i][4:2]));
        w = wake_cnt; s = smi_cnt;
        press(5);
        check("R3 wake pulse", wake_cnt, w + 1);
        check("R3 state S0", state_o, 0);
        check("R3 no smi", smi_cnt, s);
      end
    end

    // R7 release before threshold: no override
    press(5);
    check("R7 short hold", state_o, 0);
    // R7 long hold from S0
    press(20);
    check("R7 override S0", state_o, 5);
    check("R5 S5 plane", slp_s5_n, 0);
    // R8 ext wake ignored after override
    w = wake_cnt;
    pulse_ext();
    check("R8 ext ignored state", state_o, 5);
    check("R8 ext ignored wake", wake_cnt, w);
    press(5);
    check("R8 button wakes", state_o, 0);
    check("R8 wake pulse", wake_cnt, w + 1);
    // R8 ext wake works without lock
    sleep_req(3'd3);
    check("R4 enter S3", state_o, 3);
    pulse_ext();
    check("R8 ext wake state", state_o, 0);
    check("R8 ext wake pulse", wake_cnt, w + 2);
    // R7 override from sleep state
    sleep_req(3'd4);
    press(20);
    check("R7 override from S4", state_o, 5);

    // R9 / R10 power good
    press(5);
    check("R3 wake before pg", state_o, 0);
    @(negedge clk) pwr_good = 1'b0;
    @(negedge clk) pwr_good = 1'b1;
    wait_n(8);
    check("R10 short low no reset", full_cnt, 0);
    check("R10 short low state", state_o, 0);
    press(20);
    check("R7 lock set", state_o, 5);
    @(negedge clk) pwr_good = 1'b0;
    wait_n(2);
    check("R9 bus_rst_n low", bus_rst_n, 0);
    wait_n(8);
    check("R9 held low", bus_rst_n, 0);
    check("R10 full reset once", full_cnt, 1);
    check("R10 state S5", state_o, 5);
    pwr_good = 1'b1;
    wait_n(3);
    check("R9 bus_rst_n released", bus_rst_n, 1);
    pulse_ext();
    check("R10 lock cleared", state_o, 0);

    finish_run();
  end

endmodule